// File: doc/BRIEF.md
# Radio Packet Transmit Sequencer

This block drives an external 2.4 GHz packet transceiver over a four-wire SPI link and sends one packet per start strobe. The local side first fills a small payload buffer. It then pulses `start` with a byte count. The sequencer does the rest on its own. It drops the radio's chip-enable line and clears any stale "data sent" flag. It loads the payload with the transmit-payload command, reads the radio configuration and writes it back with the transmit selection in force. It fires a timed chip-enable pulse and polls the radio status until the packet has left. Last, it clears the flag again, puts the radio back into receive mode if it had been there, and signals `done`.

The SPI byte engine (mode 0, 8-bit, most significant bit first) is part of the block. All wall-clock intervals are down-counters sized from the `CLK_FREQ_HZ` parameter. An optional poll limit ends a sequence with an error flag when the radio never reports completion.

Top module: `pkt_tx_seq`

## Requirements
- R1: After reset `csn`=1, `sck`=0, `ce`=0, `busy`=0, `done`=0 and `err`=0.
- R2: A `start` with `start_len`=0 raises `done` for one cycle, in the cycle after `start` is sampled, with `err`=0. No SPI frame is sent and `ce` is unchanged.
- R3: A `start_len` above MAX_LEN (32) is clipped, so exactly 32 payload bytes are sent.
- R4: The first frame of a sequence is the two bytes 0x27, 0x20. This writes bit 5 of the radio status register, which clears it.
- R5: The second frame is 0xA0 followed by the payload bytes from buffer addresses 0, 1, … in that order, all within one `csn`-low frame.
- R6: The third frame is 0x00, 0xFF, and reads the configuration byte V. The fourth is 0x20, W, where W = V with bit 0 cleared and bit 1 set.
- R7: If bit 1 of V was 0, `ce` rises no sooner than PWRUP_US (4500 µs) after the fourth frame ends. If bit 1 was 1, no such wait is inserted.
- R8: `ce` is high for at least CE_US (10 µs) and then low. It stays low in every cycle in which `csn` is low.
- R9: Poll frames are the single byte 0xFF. They repeat until the status byte returned in them has bit 5 set.
- R10: After a successful poll, the frame 0x27, 0x20 follows. If bit 0 of V was 1, it is followed by 0x20, (W | 0x01). If bit 0 was 0, no further frame is sent.
- R11: When `done` pulses, `ce` returns to the value `ce_idle` had when `start` was accepted. Later changes of `ce_idle` have no effect.
- R12: Every falling edge of `csn` comes at least GAP_US (4 µs) after the last change of `ce`.
- R13: SPI runs in mode 0. `sck` idles low. Data is sent most significant bit first. `mosi` changes only while `sck` is low. `miso` is sampled on the rising edge of `sck`.
- R14: With POLL_LIMIT > 0, POLL_LIMIT poll frames without bit 5 end the sequence with `done` and `err`=1. No clear or restore frame is sent, and `ce` is still restored. `err` clears at the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pl_we | input | 1 | Payload buffer write strobe |
| pl_addr | input | 5 | Payload buffer write address |
| pl_wdata | input | 8 | Payload buffer write byte |
| start | input | 1 | Start strobe, sampled while idle |
| start_len | input | 6 | Requested payload length in bytes |
| ce_idle | input | 1 | Chip-enable level to restore at the end |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last sequence ended by poll timeout |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | SPI data to radio |
| miso | input | 1 | SPI data from radio |
| csn | output | 1 | SPI chip select, active low |
| ce | output | 1 | Radio chip enable |

## Verification
The zero-length `done` is due one cycle after `start` is sampled, and the bench looks for it at the very next falling clock edge. Every other result arrives after a data-dependent number of SPI frames and timed waits. For these the bench waits for the `done` pulse and then compares its record of each frame against an expected frame list. That list is built from the requirements, the starting configuration and the number of polls the radio model withholds completion. Interval rules (chip-enable width, the gap before chip select, the power-up wait) are measured in clock cycles between the edges seen at the ports. These measurements are compared with the cycle counts derived from the clock frequency parameter.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
  localparam logic [7:0] OP_WR_STATUS = 8'h27;
  localparam logic [7:0] OP_LOAD      = 8'hA0;
  localparam logic [7:0] OP_RD_CFG    = 8'h00;
  localparam logic [7:0] OP_WR_CFG    = 8'h20;
  localparam logic [7:0] OP_NOP       = 8'hFF;
  localparam logic [7:0] DS_CLEAR     = 8'h20;
  localparam int DS_BIT  = 5;
  localparam int RX_BIT  = 0;
  localparam int PWR_BIT = 1;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_CSN, ST_GO, ST_WAIT, ST_END,
    ST_PWR, ST_CEHI, ST_CEGAP, ST_FIN
  } seq_st_t;

  typedef enum logic [2:0] {
    FR_CLR1, FR_LOAD, FR_RDCFG, FR_WRCFG, FR_POLL, FR_CLR2, FR_RESTORE
  } frame_t;

  function automatic int unsigned us_to_cyc(longint unsigned hz, longint unsigned us);
    longint unsigned c;
    c = (hz * us + 64'd999999) / 64'd1000000;
    return (c == 0) ? 32'd1 : c[31:0];
  endfunction
endpackage

// File: rtl/pl_ram.sv
module pl_ram #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rq
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rq <= mem[ra];
  end
endmodule

// File: rtl/tx_delay.sv
module tx_delay #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          fire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign fire = (cnt == CW'(1)) && !load;
endmodule

// File: rtl/spi_byte_eng.sv
module spi_byte_eng #(
  parameter int SCK_HALF = 5,
  localparam int HW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  logic          act;
  logic [HW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0; cnt <= '0; bitn <= '0; sh <= '0;
      sck <= 1'b0; mosi <= 1'b0; done <= 1'b0; rx <= '0;
    end else begin
      done <= 1'b0;
      if (!act) begin
        if (go) begin
          act  <= 1'b1;
          sh   <= tx;
          mosi <= tx[7];
          cnt  <= HW'(SCK_HALF - 1);
          bitn <= '0;
          sck  <= 1'b0;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= HW'(SCK_HALF - 1);
        if (!sck) begin
          sck <= 1'b1;
          rx  <= {rx[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bitn == 3'd7) begin
            act  <= 1'b0;
            done <= 1'b1;
          end else begin
            bitn <= bitn + 1'b1;
            sh   <= {sh[6:0], 1'b0};
            mosi <= sh[6];
          end
        end
      end
    end
  end

  // R13
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi));
endmodule

// File: rtl/pkt_tx_seq.sv
module pkt_tx_seq
  import pkt_tx_pkg::*;
#(
  parameter longint unsigned CLK_FREQ_HZ = 100_000_000,
  parameter int SCK_HALF   = 5,
  parameter int MAX_LEN    = 32,
  parameter int POLL_LIMIT = 1000,
  parameter int CE_US      = 10,
  parameter int GAP_US     = 4,
  parameter int PWRUP_US   = 4500,
  localparam int AW    = $clog2(MAX_LEN),
  localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pl_we,
  input  logic [AW-1:0]    pl_addr,
  input  logic [7:0]       pl_wdata,
  input  logic             start,
  input  logic [LEN_W-1:0] start_len,
  input  logic             ce_idle,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic             csn,
  output logic             ce
);
  localparam int unsigned GAP_CYC = us_to_cyc(CLK_FREQ_HZ, 64'(GAP_US));
  localparam int unsigned CE_CYC  = us_to_cyc(CLK_FREQ_HZ, 64'(CE_US));
  localparam int unsigned PWR_CYC = us_to_cyc(CLK_FREQ_HZ, 64'(PWRUP_US));
  localparam int unsigned TMAX    = (PWR_CYC > CE_CYC) ?
                                    ((PWR_CYC > GAP_CYC) ? PWR_CYC : GAP_CYC) :
                                    ((CE_CYC > GAP_CYC) ? CE_CYC : GAP_CYC);
  localparam int TW = $clog2(TMAX + 2);
  localparam int PW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT + 1) : 1;
  localparam logic [TW-1:0] GAP_T = TW'(GAP_CYC);
  localparam logic [TW-1:0] CE_T  = TW'(CE_CYC);
  localparam logic [TW-1:0] PWR_T = TW'(PWR_CYC);

  seq_st_t          st;
  frame_t           fr;
  logic [LEN_W-1:0] fidx, flen, len_q;
  logic             ce_q, ce_sv, csn_q, busy_q, done_q, err_q, to_q;
  logic [7:0]       cfg_q;
  logic             ds_seen;
  logic [PW-1:0]    poll_cnt;
  logic [PW-1:0]    poll_nxt;
  logic             tmr_ld, tmr_fire;
  logic [TW-1:0]    tmr_val;
  logic             eng_go, eng_done;
  logic [7:0]       eng_tx, eng_rx, buf_q, cfg_tx;
  logic [AW-1:0]    rd_addr;

  assign cfg_tx   = {cfg_q[7:2], 1'b1, 1'b0};
  assign rd_addr  = fidx[AW-1:0] - 1'b1;
  assign eng_go   = (st == ST_GO);
  assign poll_nxt = poll_cnt + 1'b1;

  pl_ram #(.DEPTH(MAX_LEN), .DW(8)) ram_i (
    .clk(clk), .we(pl_we), .wa(pl_addr), .wd(pl_wdata), .ra(rd_addr), .rq(buf_q));

  tx_delay #(.CW(TW)) tmr_i (
    .clk(clk), .rst(rst), .load(tmr_ld), .val(tmr_val), .fire(tmr_fire));

  spi_byte_eng #(.SCK_HALF(SCK_HALF)) eng_i (
    .clk(clk), .rst(rst), .go(eng_go), .tx(eng_tx), .miso(miso),
    .sck(sck), .mosi(mosi), .done(eng_done), .rx(eng_rx));

  always_comb begin
    case (fr)
      FR_CLR1, FR_CLR2: eng_tx = (fidx == '0) ? OP_WR_STATUS : DS_CLEAR;
      FR_LOAD:          eng_tx = (fidx == '0) ? OP_LOAD      : buf_q;
      FR_RDCFG:         eng_tx = (fidx == '0) ? OP_RD_CFG    : OP_NOP;
      FR_WRCFG:         eng_tx = (fidx == '0) ? OP_WR_CFG    : cfg_tx;
      FR_RESTORE:       eng_tx = (fidx == '0) ? OP_WR_CFG    : (cfg_tx | 8'h01);
      default:          eng_tx = OP_NOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; fr <= FR_CLR1; fidx <= '0; flen <= '0; len_q <= '0;
      ce_q <= 1'b0; ce_sv <= 1'b0; csn_q <= 1'b1; busy_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0; to_q <= 1'b0; cfg_q <= '0;
      ds_seen <= 1'b0; poll_cnt <= '0; tmr_ld <= 1'b0; tmr_val <= '0;
    end else begin
      tmr_ld <= 1'b0;
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          err_q <= 1'b0;
          if (start_len == '0) begin
            done_q <= 1'b1;
          end else begin
            len_q    <= (start_len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : start_len;
            ce_sv    <= ce_idle;
            ce_q     <= 1'b0;
            busy_q   <= 1'b1;
            to_q     <= 1'b0;
            poll_cnt <= '0;
            tmr_ld   <= 1'b1;
            tmr_val  <= GAP_T;
            st       <= ST_PRE;
          end
        end
        ST_PRE: if (tmr_fire) begin
          fr <= FR_CLR1; flen <= LEN_W'(2); fidx <= '0; st <= ST_CSN;
        end
        ST_CSN: begin
          csn_q <= 1'b0;
          st    <= ST_GO;
        end
        ST_GO: st <= ST_WAIT;
        ST_WAIT: if (eng_done) begin
          if (fr == FR_RDCFG && fidx == LEN_W'(1)) cfg_q <= eng_rx;
          if (fr == FR_POLL) ds_seen <= eng_rx[DS_BIT];
          if (fidx == flen - 1'b1) begin
            st <= ST_END;
          end else begin
            fidx <= fidx + 1'b1;
            st   <= ST_CSN;
          end
        end
        ST_END: begin
          csn_q <= 1'b1;
          fidx  <= '0;
          st    <= ST_CSN;
          case (fr)
            FR_CLR1:  begin fr <= FR_LOAD;  flen <= len_q + 1'b1; end
            FR_LOAD:  begin fr <= FR_RDCFG; flen <= LEN_W'(2); end
            FR_RDCFG: begin fr <= FR_WRCFG; flen <= LEN_W'(2); end
            FR_WRCFG: begin
              tmr_ld <= 1'b1;
              if (!cfg_q[PWR_BIT]) begin
                tmr_val <= PWR_T;
                st      <= ST_PWR;
              end else begin
                ce_q    <= 1'b1;
                tmr_val <= CE_T;
                st      <= ST_CEHI;
              end
            end
            FR_POLL: begin
              poll_cnt <= poll_nxt;
              if (ds_seen) begin
                fr <= FR_CLR2; flen <= LEN_W'(2);
              end else if (POLL_LIMIT != 0 && poll_nxt == PW'(POLL_LIMIT)) begin
                to_q <= 1'b1;
                st   <= ST_FIN;
              end else begin
                fr <= FR_POLL; flen <= LEN_W'(1);
              end
            end
            FR_CLR2: begin
              if (cfg_q[RX_BIT]) begin
                fr <= FR_RESTORE; flen <= LEN_W'(2);
              end else begin
                st <= ST_FIN;
              end
            end
            default: st <= ST_FIN;
          endcase
        end
        ST_PWR: if (tmr_fire) begin
          ce_q <= 1'b1; tmr_ld <= 1'b1; tmr_val <= CE_T; st <= ST_CEHI;
        end
        ST_CEHI: if (tmr_fire) begin
          ce_q <= 1'b0; tmr_ld <= 1'b1; tmr_val <= GAP_T; st <= ST_CEGAP;
        end
        ST_CEGAP: if (tmr_fire) begin
          fr <= FR_POLL; flen <= LEN_W'(1); fidx <= '0; st <= ST_CSN;
        end
        ST_FIN: begin
          ce_q   <= ce_sv;
          busy_q <= 1'b0;
          done_q <= 1'b1;
          err_q  <= to_q;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign err  = err_q;
  assign csn  = csn_q;
  assign ce   = ce_q;

  // interval trackers for the timing checks below
  logic          ce_prev;
  logic [TW-1:0] gap_cnt, hi_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      ce_prev <= 1'b0; gap_cnt <= '0; hi_cnt <= '0;
    end else begin
      ce_prev <= ce_q;
      if (ce_q != ce_prev)    gap_cnt <= '0;
      else if (gap_cnt < GAP_T) gap_cnt <= gap_cnt + 1'b1;
      if (!ce_q)              hi_cnt <= '0;
      else if (hi_cnt < CE_T) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R12
  ce_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(csn_q) |-> gap_cnt >= GAP_T);
  // R8
  ce_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !csn_q |-> !ce_q);
  // R8
  ce_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(ce_q) && st == ST_CEGAP) |-> hi_cnt >= CE_T);
  // R13
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    csn_q |-> !sck);
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R14
  err_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> done_q);
endmodule

// File: tb/pkt_tx_seq_tb.sv
module pkt_tx_seq_tb_top;
  localparam int LIMIT = 8;
  localparam int PWR_C = 4500;
  localparam int CE_C  = 10;
  localparam int GAP_C = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic       pl_we = 0;
  logic [4:0] pl_addr = 0;
  logic [7:0] pl_wdata = 0;
  logic       start = 0;
  logic [5:0] start_len = 0;
  logic       ce_idle = 0;
  logic       miso = 0;
  logic       busy, done, err, sck, mosi, csn, ce;

  pkt_tx_seq #(.CLK_FREQ_HZ(64'd1_000_000), .SCK_HALF(2), .MAX_LEN(32),
               .POLL_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst(rst), .pl_we(pl_we), .pl_addr(pl_addr), .pl_wdata(pl_wdata),
    .start(start), .start_len(start_len), .ce_idle(ce_idle),
    .busy(busy), .done(done), .err(err), .sck(sck), .mosi(mosi), .miso(miso),
    .csn(csn), .ce(ce));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_ge(string req, string what, longint act, longint lo);
    n_chk++;
    if (act < lo) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected >= %0d", req, what, act, lo);
    end
  endtask

  // ---------------- radio model ----------------
  logic [7:0] m_cfg = 0, m_stat = 0;
  int         m_k = 0, ds_cnt = 0;
  bit         ds_pend = 0;
  logic [7:0] log_b [256];
  int         log_n = 0, fr_n = 0, cur_len = 0, bitc = 0;
  int         fr_len [64];
  logic [7:0] sh_in = 0, sh_out = 0, cur_cmd = 0;

  always @(negedge csn) begin
    cur_len = 0; bitc = 0;
    sh_out = m_stat;
    miso = sh_out[7];
  end

  always @(posedge sck) if (csn === 1'b0) begin
    sh_in = {sh_in[6:0], mosi};
    bitc++;
    if (bitc == 8) begin
      bitc = 0;
      if (log_n < 256) log_b[log_n] = sh_in;
      log_n++;
      cur_len++;
      if (cur_len == 1) cur_cmd = sh_in;
      sh_out = (cur_cmd == 8'h00) ? m_cfg : 8'h00;
    end
  end

  always @(negedge sck) if (csn === 1'b0) begin
    if (bitc != 0) sh_out = {sh_out[6:0], 1'b0};
    miso = sh_out[7];
  end

  always @(posedge csn) if (cur_len > 0) begin
    if (fr_n < 64) fr_len[fr_n] = cur_len;
    fr_n++;
    if (cur_cmd == 8'h27 && cur_len >= 2) m_stat = m_stat & ~log_b[log_n - cur_len + 1];
    if (cur_cmd == 8'h20 && cur_len >= 2) m_cfg = log_b[log_n - cur_len + 1];
    if (cur_cmd == 8'hFF && ds_pend) begin
      ds_cnt++;
      if (ds_cnt >= m_k) begin m_stat = m_stat | 8'h20; ds_pend = 0; end
    end
    cur_len = 0;
  end

  always @(negedge ce) if (busy === 1'b1) begin
    ds_pend = 1; ds_cnt = 0;
    if (m_k == 0) begin m_stat = m_stat | 8'h20; ds_pend = 0; end
  end

  // ---------------- port monitors ----------------
  int  cyc = 0, last_ce_chg = 0, last_csn_rise = 0, ce_rise_cyc = 0;
  int  min_gap = 1 << 30, hi_len = 0, pwr_gap = 0, ce_bad = 0, mode_bad = 0;
  bit  hi_arm = 0;
  logic p_ce = 0, p_csn = 1, p_sck = 0, p_mosi = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (ce !== p_ce) begin
        if (ce && busy) begin
          ce_rise_cyc = cyc; pwr_gap = cyc - last_csn_rise; hi_arm = 1;
        end
        if (!ce && hi_arm) begin hi_len = cyc - ce_rise_cyc; hi_arm = 0; end
        last_ce_chg = cyc;
      end
      if (!csn && p_csn && (cyc - last_ce_chg) < min_gap) min_gap = cyc - last_ce_chg;
      if (csn && !p_csn) last_csn_rise = cyc;
      if (ce && !csn) ce_bad++;
      if (sck && p_sck && mosi !== p_mosi) mode_bad++;
      if (csn && sck) mode_bad++;
    end
    p_ce = ce; p_csn = csn; p_sck = sck; p_mosi = mosi;
  end

  // ---------------- expected frames ----------------
  logic [7:0] exp_b [256];
  int exp_fl [64];
  int exp_bn, exp_fn;

  task automatic push(int n, logic [7:0] b0, logic [7:0] b1);
    exp_b[exp_bn] = b0; exp_bn++;
    if (n > 1) begin exp_b[exp_bn] = b1; exp_bn++; end
    exp_fl[exp_fn] = n; exp_fn++;
  endtask

  function automatic logic [7:0] pat(int i, int v);
    return 8'(i * 37 + v * 11 + 5);
  endfunction

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
    if (!ok) begin n_chk++; n_bad++; $display("FAIL watchdog: done never seen"); end
  endtask

  task automatic run_txn(int v, int len, logic [7:0] cfg, logic cel, int k);
    int eff, npoll, bi;
    bit ok, success;
    logic [7:0] w;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); pl_we = 1; pl_addr = 5'(i); pl_wdata = pat(i, v);
    end
    @(negedge clk); pl_we = 0;
    m_cfg = cfg; m_stat = 8'h2E; m_k = k; ds_pend = 0;
    log_n = 0; fr_n = 0; min_gap = 1 << 30; hi_len = 0; pwr_gap = 0;
    ce_bad = 0; mode_bad = 0;
    eff = (len > 32) ? 32 : len;
    w = (cfg & 8'hFE) | 8'h02;
    success = (k + 1 <= LIMIT);
    npoll = success ? k + 1 : LIMIT;
    exp_bn = 0; exp_fn = 0;
    push(2, 8'h27, 8'h20);
    exp_b[exp_bn] = 8'hA0; exp_bn++;
    for (int i = 0; i < eff; i++) begin exp_b[exp_bn] = pat(i, v); exp_bn++; end
    exp_fl[exp_fn] = eff + 1; exp_fn++;
    push(2, 8'h00, 8'hFF);
    push(2, 8'h20, w);
    for (int i = 0; i < npoll; i++) push(1, 8'hFF, 8'h00);
    if (success) begin
      push(2, 8'h27, 8'h20);
      if (cfg[0]) push(2, 8'h20, w | 8'h01);
    end
    start = 1; start_len = 6'(len); ce_idle = cel;
    @(negedge clk); start = 0;
    ce_idle = ~cel;   // R11: later changes must not matter
    wait_done(ok);
    if (!ok) return;
    chk("R9/R10", $sformatf("vec%0d frame count", v), fr_n, exp_fn);
    for (int f = 0; f < exp_fn && f < fr_n; f++)
      chk("R5", $sformatf("vec%0d frame %0d length", v, f), fr_len[f], exp_fl[f]);
    bi = (log_n < exp_bn) ? log_n : exp_bn;
    for (int i = 0; i < bi; i++)
      chk((i < 2) ? "R4" : (i < eff + 3) ? "R5" : "R6/R9/R10",
          $sformatf("vec%0d byte %0d", v, i), log_b[i], exp_b[i]);
    if (len > 32) chk("R3", $sformatf("vec%0d payload frame length", v), fr_len[1], 33);
    chk("R14", $sformatf("vec%0d err", v), err, success ? 0 : 1);
    chk("R11", $sformatf("vec%0d ce restored", v), ce, cel);
    chk_ge("R12", $sformatf("vec%0d ce-to-csn gap", v), min_gap, GAP_C);
    chk_ge("R8", $sformatf("vec%0d ce high width", v), hi_len, CE_C);
    chk("R8", $sformatf("vec%0d ce high during frame", v), ce_bad, 0);
    chk("R13", $sformatf("vec%0d spi mode 0 violations", v), mode_bad, 0);
    if (!cfg[1]) chk_ge("R7", $sformatf("vec%0d power-up wait", v), pwr_gap, PWR_C);
    else chk("R7", $sformatf("vec%0d no power-up wait", v), (pwr_gap < PWR_C) ? 1 : 0, 1);
    @(negedge clk);
    chk("R2", $sformatf("vec%0d done is one cycle", v), done, 0);
  endtask

  // vector: len[22:17] cfg[16:9] ce_idle[8] polls_withheld[7:0]
  localparam logic [22:0] VEC [5] = '{
    {6'd5,  8'h0B, 1'b1, 8'd1},
    {6'd1,  8'h08, 1'b0, 8'd0},
    {6'd32, 8'h0A, 1'b0, 8'd3},
    {6'd40, 8'h09, 1'b1, 8'd2},
    {6'd17, 8'h7F, 1'b1, 8'd0}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "csn", csn, 1);
    chk("R1", "sck", sck, 0);
    chk("R1", "ce", ce, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "err", err, 0);

    for (int v = 0; v < 5; v++)
      run_txn(v, int'(VEC[v][22:17]), VEC[v][16:9], VEC[v][8], int'(VEC[v][7:0]));

    // R14 poll timeout: radio never reports completion
    run_txn(7, 3, 8'h0A, 1'b1, 255);

    // R2 zero length: immediate done, no frame, ce unchanged, err cleared (R14)
    begin
      int fn0;
      logic ce0;
      fn0 = fr_n; ce0 = ce;
      start = 1; start_len = 0; ce_idle = ~ce0;
      @(negedge clk); start = 0;
      chk("R2", "zero-length done", done, 1);
      chk("R14", "err cleared by new start", err, 0);
      chk("R2", "zero-length busy", busy, 0);
      repeat (20) @(negedge clk);
      chk("R2", "zero-length frames", fr_n - fn0, 0);
      chk("R2", "zero-length ce unchanged", ce, ce0);
    end

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule